// File: doc/BRIEF.md
# Write-Protected Programmable Reference Divider

This block thins a reference clock into a stream of one-cycle enable pulses, one every R reference cycles. The phase comparator of a frequency synthesiser consumes these pulses. Software picks R through an 8-bit select register. Only its low nibble is stored; the high nibble always reads back as zero. A select value of zero is treated as a divide factor of one.

The register is frozen while the synthesiser loop is running. When the loop-enable input is high, write strobes are discarded and the stored value is kept. A value written while the loop is off is not used at once. It is taken up at the end of the current division period, so the comparator never sees a shortened period.

Top module: `refdiv_top`

## Requirements
- R1: Read data bits 3:0 return the stored select value. Bits 7:4 always read 0, whatever was written to them.
- R2: While `rst` is high, and right after it is released, the select register holds 1 and the internal count is 0. The first cycle after reset release therefore has `div_pulse` high.
- R3: A write (`wr_en` high, `pll_on` low, at a rising clock edge) stores `wr_data[3:0]`. The new value is visible on `rd_data` from the next cycle.
- R4: A write strobe while `pll_on` is high leaves the stored select value unchanged.
- R5: The divide factor is the stored select value, except that a value of 0 divides exactly like a value of 1.
- R6: `div_pulse` is high for exactly one cycle in every R cycles. With R equal to 1 it is high on every cycle.
- R7: A changed select value takes effect only after the pulse that ends the current period. The period in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the select register |
| wr_data | input | 8 | Write data; only bits 3:0 are stored |
| pll_on | input | 1 | Loop enable; while high, writes are discarded |
| rd_data | output | 8 | Select register read-back |
| div_pulse | output | 1 | One-cycle pulse every R reference cycles |

## Verification
The bench writes 0 and checks that the output becomes a continuous high level. A design that divided literally by zero would stall or wrap instead. It tries a write while the loop is enabled; a design without the lock would change the read-back and the pulse spacing. It also rewrites the select value in the middle of a long period. A design that loaded the new value at once would produce a runt or stretched period, and the cycle-exact model flags it. Writes with the high nibble set are read back to catch unimplemented bits that leak through.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  parameter int unsigned SEL_W = 4;
  parameter int unsigned REG_W = 8;
  typedef logic [SEL_W-1:0] sel_t;

  // Effective division factor: a zero selection behaves as one.
  function automatic sel_t eff_div(input sel_t s);
    return (s == '0) ? sel_t'(1) : s;
  endfunction
endpackage

// File: rtl/refdiv_selreg.sv
module refdiv_selreg
  import refdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             pll_on,
  output sel_t             sel_q,
  output logic [REG_W-1:0] rd_data
);
  localparam int unsigned PAD_W = REG_W - SEL_W;

  logic wr_accept;
  logic wr_blocked;
  assign wr_accept  = wr_en & ~pll_on;
  assign wr_blocked = wr_en & pll_on;

  always_ff @(posedge clk) begin
    if (rst)            sel_q <= sel_t'(1);
    else if (wr_accept) sel_q <= wr_data[SEL_W-1:0];
  end

  assign rd_data = {{PAD_W{1'b0}}, sel_q};

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    rd_data[REG_W-1:SEL_W] == '0);
  p_reset_sel_r2: assert property (@(posedge clk)
    rst |=> (sel_q == sel_t'(1)));
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> (sel_q == $past(wr_data[SEL_W-1:0])));
  p_locked_hold_r4: assert property (@(posedge clk) disable iff (rst)
    wr_blocked |=> $stable(sel_q));
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
  import refdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  sel_t sel_q,
  output logic div_pulse
);
  sel_t cnt_q;
  sel_t cur_div_q;
  logic term_cnt;

  assign term_cnt  = (cnt_q == sel_t'(cur_div_q - sel_t'(1)));
  assign div_pulse = term_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      cur_div_q <= sel_t'(1);
    end else if (term_cnt) begin
      cnt_q     <= '0;
      cur_div_q <= eff_div(sel_q);
    end else begin
      cnt_q     <= cnt_q + sel_t'(1);
    end
  end

  p_zero_as_one_r5: assert property (@(posedge clk) disable iff (rst)
    term_cnt |=> (cur_div_q != '0));
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    term_cnt |=> (cnt_q == '0));
  p_no_midload_r7: assert property (@(posedge clk) disable iff (rst)
    !term_cnt |=> $stable(cur_div_q));
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             pll_on,
  output logic [REG_W-1:0] rd_data,
  output logic             div_pulse
);
  sel_t sel_q;

  refdiv_selreg u_selreg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .pll_on  (pll_on),
    .sel_q   (sel_q),
    .rd_data (rd_data)
  );

  refdiv_counter u_counter (
    .clk       (clk),
    .rst       (rst),
    .sel_q     (sel_q),
    .div_pulse (div_pulse)
  );
endmodule

// File: tb/test_refdiv_top.sv
`timescale 1ns/1ps
module test_refdiv_top;
  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic       pll_on = 0;
  logic [7:0] rd_data;
  logic       div_pulse;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string tag = "R6";

  // Behavioural model: cycles remaining until the next pulse.
  int m_sel = 1;
  int m_rem = 0;

  refdiv_top i_refdiv_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pll_on(pll_on), .rd_data(rd_data), .div_pulse(div_pulse)
  );

  always #2.5 clk = ~clk;

  function automatic int factor(int s);
    return (s == 0) ? 1 : s;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_sel = 1;
      m_rem = 0;
    end else begin
      if (m_rem == 0) m_rem = factor(m_sel) - 1;
      else            m_rem = m_rem - 1;
      if (wr_en && !pll_on) m_sel = wr_data & 8'h0F;
    end
  end

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst) begin
      check({tag, " pulse"}, div_pulse, (m_rem == 0) ? 1 : 0);
      check("R1 readback", rd_data, m_sel);
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d, logic lock);
    @(negedge clk); #0.5;
    wr_data = d; pll_on = lock; wr_en = 1;
    @(negedge clk); #0.5;
    wr_en = 0;
  endtask

  initial begin
    run(3);
    #0.5 rst = 0;
    @(negedge clk);
    check("R2 reset select", rd_data, 1);
    check("R2 first pulse", div_pulse, 1);
    tag = "R6"; run(6);                 // divide by 1: pulse on every cycle
    tag = "R3"; wr(8'h03, 0);
    check("R3 write visible", rd_data, 3);
    tag = "R6"; run(15);
    tag = "R1"; wr(8'hF5, 0);
    check("R1 upper bits zero", rd_data, 5);
    run(17);
    tag = "R4"; wr(8'h02, 1);
    check("R4 locked write ignored", rd_data, 5);
    run(17);
    pll_on = 0;
    tag = "R5"; wr(8'h00, 0);
    check("R5 zero stored", rd_data, 0);
    run(12);
    tag = "R7"; wr(8'h0C, 0);
    run(5);
    wr(8'h02, 0);                       // change in the middle of a long period
    run(20);
    tag = "R6"; wr(8'h0F, 0);
    run(50);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule